// File: doc/BRIEF.md
# Ripple-Carry ALU with Overflow-Corrected Signed Compare

This block is an arithmetic-logic unit of parameterised width for two's-complement operands. It is built from a chain of identical one-bit slices and one distinct top slice. Each slice forms the AND, the OR or a full-adder sum of its operand bit `a` and either `b` or its inverse. The carry ripples from bit 0 upward. A two-bit operation select picks which of these each slice presents, and a separate invert control and a carry-in let the same adder perform addition and subtraction.

The top slice has two extra outputs. It reports signed overflow, which is the carry into the top bit XOR the carry out of it. It also reports a corrected less-than bit, which is the top sum bit XOR that overflow. The corrected bit is routed back to the less-than input of bit 0, and every other slice has that input tied to 0. A signed compare therefore gives the right answer even when the internal subtraction wraps. For example, with four bits, -7 minus 6 wraps to 0011, yet the compare still reports that -7 is less than 6.

The result, the zero flag, the carry-out and the overflow flag are captured in a register stage. They appear one clock after the operands are presented.

Top module: `ripple_slt_alu`

## Requirements
- R1: With op_sel = 2'b00 (AND) and b_invert = 0, result is the bitwise AND of a_in and b_in.
- R2: With op_sel = 2'b01 (OR) and b_invert = 0, result is the bitwise OR of a_in and b_in.
- R3: With op_sel = 2'b10 (add) and b_invert = 0, result is the low WIDTH bits of a_in + b_in + carry_in. In every mode, carry_out is bit WIDTH of a_in + (b_invert ? ~b_in : b_in) + carry_in.
- R4: With op_sel = 2'b10, b_invert = 1 and carry_in = 1, result is a_in - b_in modulo 2^WIDTH. carry_out is 1 exactly when a_in >= b_in as unsigned values.
- R5: With op_sel = 2'b11 (set-less-than), b_invert = 1 and carry_in = 1, result bit 0 is 1 exactly when a_in < b_in as signed values, and all higher bits are 0. This holds when the internal subtraction overflows (4-bit -7 vs 6 gives 1; -8 vs 7 gives 1; 7 vs -8 gives 0).
- R6: With op_sel = 2'b10, overflow is 1 exactly when the two adder operands (a_in and b_in or ~b_in) have equal sign bits and the sign bit of result differs from them.
- R7: With op_sel = 2'b00, 2'b01 or 2'b11, overflow is 0.
- R8: zero is 1 exactly when every bit of result is 0.
- R9: All outputs are registered and reflect the inputs sampled at the previous rising edge of clk. A synchronous active-high rst clears result, carry_out and overflow to 0 and sets zero to 1.
- R10: In AND and OR modes, b_invert = 1 makes the operation use ~b_in in place of b_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| b_invert | input | 1 | Feed ~b_in to the slices instead of b_in |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 add, 11 set-less-than |
| result | output | WIDTH | Registered operation result |
| zero | output | 1 | Registered all-zero flag of result |
| carry_out | output | 1 | Registered carry out of the top slice |
| overflow | output | 1 | Registered signed overflow, add mode only |

## Verification
Every result, flag and carry is due exactly one rising edge after the operands are applied. The reset values are due one edge after rst is raised. The bench applies each operand set on a falling edge and queues the expected outcome. A monitor wakes 1 ns after each rising edge and pops one queued item per edge, so each comparison lines up with the single register stage and no item is compared early or late. The 4-bit instance is swept over all operand pairs in each mode. The queue order alone ties every response to its stimulus.

// File: rtl/alu_rip_pkg.sv
package alu_rip_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SLT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic cout;
        logic ovf;
    } alu_flags_t;

    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (x & c) | (y & c);
    endfunction

    function automatic logic slice_mux(input alu_op_e op, input logic and_v,
                                       input logic or_v, input logic sum_v,
                                       input logic less_v);
        logic r;
        unique case (op)
            OP_AND:  r = and_v;
            OP_OR:   r = or_v;
            OP_ADD:  r = sum_v;
            default: r = less_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_rip_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    b_inv,
    input  logic    cin,
    input  logic    less,
    input  alu_op_e op,
    output logic    res,
    output logic    cout
);
    logic b_eff;

    always_comb begin
        b_eff = b ^ b_inv;
        cout  = fa_carry(a, b_eff, cin);
        res   = slice_mux(op, a & b_eff, a | b_eff, fa_sum(a, b_eff, cin), less);
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_rip_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    b_inv,
    input  logic    cin,
    input  alu_op_e op,
    output logic    res,
    output logic    cout,
    output logic    ovf_raw,
    output logic    lt_set
);
    logic b_eff;
    logic sum_bit;

    always_comb begin
        b_eff   = b ^ b_inv;
        sum_bit = fa_sum(a, b_eff, cin);
        cout    = fa_carry(a, b_eff, cin);
        // overflow: carry entering the sign bit disagrees with carry leaving it
        ovf_raw = cin ^ cout;
        // corrected less-than: sign of the difference, flipped when it wrapped
        lt_set  = sum_bit ^ ovf_raw;
        // the top slice's less input is always 0
        res     = slice_mux(op, a & b_eff, a | b_eff, sum_bit, 1'b0);
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_rip_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  alu_op_e          op,
    input  logic             cout_raw,
    input  logic             ovf_raw,
    output alu_flags_t       flags
);
    always_comb begin
        flags.zero = ~(|res);
        flags.cout = cout_raw;
        flags.ovf  = (op == OP_ADD) ? ovf_raw : 1'b0;
    end
endmodule

// File: rtl/ripple_slt_alu.sv
module ripple_slt_alu
    import alu_rip_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_invert,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic             carry_chain [WIDTH+1];
    logic             res_bit     [WIDTH];
    logic [WIDTH-1:0] res_comb;
    logic             lt_set;
    logic             ovf_raw;
    alu_flags_t       flags_comb;
    alu_flags_t       flags_q;

    assign op             = alu_op_e'(op_sel);
    assign carry_chain[0] = carry_in;

    generate
        if (WIDTH < 2) begin : g_bad_width
            initial $error("ripple_slt_alu needs WIDTH >= 2");
        end

        for (genvar i = 0; i < MSB; i++) begin : g_slice
            logic less_in;
            if (i == 0) begin : g_lsb
                assign less_in = lt_set;
            end else begin : g_mid
                assign less_in = 1'b0;
            end
            alu_bit_slice u_slice (
                .a     (a_in[i]),
                .b     (b_in[i]),
                .b_inv (b_invert),
                .cin   (carry_chain[i]),
                .less  (less_in),
                .op    (op),
                .res   (res_bit[i]),
                .cout  (carry_chain[i+1])
            );
        end
    endgenerate

    alu_msb_slice u_msb (
        .a       (a_in[MSB]),
        .b       (b_in[MSB]),
        .b_inv   (b_invert),
        .cin     (carry_chain[MSB]),
        .op      (op),
        .res     (res_bit[MSB]),
        .cout    (carry_chain[WIDTH]),
        .ovf_raw (ovf_raw),
        .lt_set  (lt_set)
    );

    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            res_comb[k] = res_bit[k];
        end
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res      (res_comb),
        .op       (op),
        .cout_raw (carry_chain[WIDTH]),
        .ovf_raw  (ovf_raw),
        .flags    (flags_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            flags_q <= '{zero: 1'b1, cout: 1'b0, ovf: 1'b0};
        end else begin
            result  <= res_comb;
            flags_q <= flags_comb;
        end
    end

    assign zero      = flags_q.zero;
    assign carry_out = flags_q.cout;
    assign overflow  = flags_q.ovf;

    // ---------------- assertions ----------------
    assert_and_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b00 && !b_invert) |=> (result == $past(a_in & b_in)));

    assert_or_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b01 && !b_invert) |=> (result == $past(a_in | b_in)));

    assert_slt_signed_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11 && b_invert && carry_in)
        |=> (result[0] == ($signed($past(a_in)) < $signed($past(b_in)))));

    assert_slt_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11) |=> (result[MSB:1] == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (op_sel != 2'b10) |=> !overflow);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        zero == (result == '0));

    assert_reset_values_R9: assert property (@(posedge clk)
        rst |=> (result == '0 && zero && !carry_out && !overflow));

endmodule

// File: tb/test_ripple_slt_alu.sv
`timescale 1ns/1ps
module test_ripple_slt_alu;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] res;
        logic         zero;
        logic         cout;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         b_invert = 1'b0;
    logic         carry_in = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] result;
    logic         zero, carry_out, overflow;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ripple_slt_alu #(.WIDTH(W)) i_ripple_slt_alu (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .b_invert(b_invert), .carry_in(carry_in), .op_sel(op_sel),
        .result(result), .zero(zero), .carry_out(carry_out), .overflow(overflow)
    );

    task automatic check_item(input exp_t e);
        n_checks++;
        if (result !== e.res || zero !== e.zero || carry_out !== e.cout || overflow !== e.ovf) begin
            n_fail++;
            $display("FAIL %s: got res=%b z=%b c=%b v=%b, expected res=%b z=%b c=%b v=%b",
                     e.tag, result, zero, carry_out, overflow, e.res, e.zero, e.cout, e.ovf);
        end
    endtask

    task automatic drive(input int op, input int a, input int b, input int inv,
                         input int cin, input string tag);
        exp_t e;
        int bv, s, r, sa, sb, co, ovr, res;
        @(negedge clk);
        op_sel   = 2'(op);
        a_in     = W'(a);
        b_in     = W'(b);
        b_invert = 1'(inv);
        carry_in = 1'(cin);
        bv  = inv ? (~b) & 15 : b;
        s   = a + bv + cin;
        r   = s & 15;
        co  = (s >> 4) & 1;
        sa  = (a >= 8) ? a - 16 : a;
        sb  = (b >= 8) ? b - 16 : b;
        ovr = (((a >> 3) & 1) == ((bv >> 3) & 1)) && (((r >> 3) & 1) != ((a >> 3) & 1));
        case (op)
            0: begin res = a & bv; ovr = 0; end
            1: begin res = a | bv; ovr = 0; end
            2: res = r;
            default: begin res = (sa < sb) ? 1 : 0; ovr = 0; end
        endcase
        e.res  = W'(res);
        e.zero = (res == 0);
        e.cout = 1'(co);
        e.ovf  = 1'(ovr);
        e.tag  = $sformatf("%s a=%0d b=%0d op=%0d inv=%0d cin=%0d", tag, a, b, op, inv, cin);
        exp_q.push_back(e);
    endtask

    // monitor: one register stage, so each item is due 1 ns after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && exp_q.size() > 0) check_item(exp_q.pop_front());
        end
    end

    task automatic check_reset(input string tag);
        exp_t e;
        e.res = '0; e.zero = 1'b1; e.cout = 1'b0; e.ovf = 1'b0; e.tag = tag;
        check_item(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset("R9 reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                drive(0, a, b, 0, 0, "R1 R7 R8 and");
                drive(0, a, b, 1, 0, "R10 R7 and-inv");
                drive(1, a, b, 0, 0, "R2 R7 R8 or");
                drive(1, a, b, 1, 1, "R10 R3 or-inv");
                drive(2, a, b, 0, 0, "R3 R6 R8 add");
                drive(2, a, b, 0, 1, "R3 R6 add-cin");
                drive(2, a, b, 1, 1, "R4 R6 R8 sub");
                drive(3, a, b, 1, 1, "R5 R7 R8 slt");
            end
        end
        // named corner cases: -7 vs 6, most negative vs most positive
        drive(3, 9, 6, 1, 1, "R5 slt -7<6");
        drive(3, 8, 7, 1, 1, "R5 slt -8<7");
        drive(3, 7, 8, 1, 1, "R5 slt 7<-8");
        drive(2, 7, 1, 0, 0, "R6 add 7+1");
        drive(2, 8, 1, 1, 1, "R6 sub -8-1");

        @(negedge clk);
        op_sel = 2'b10; a_in = 4'd7; b_in = 4'd7; b_invert = 1'b0; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_reset("R9 mid-run reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule